// File: doc/BRIEF.md
# Programmable Interval Tick Timer

This block produces a periodic interrupt for a processor. Software sets the period through a 32-bit register write: the low 9 bits hold a reload value R, and the interrupt repeats every R+1 milliseconds. A free-running prescaler divides the system clock down to a one-millisecond pulse, and a period counter counts those pulses up to R.

When the period counter reaches R on a millisecond pulse, the interrupt line goes high and the next period starts on its own. Software clears the line in one of two ways. It can read the acknowledge register, which returns no data. It can also write a new reload value, which clears the line and starts the period again from zero. Every other bus access leaves the timer alone.

Top module: `tick_timer_top`

## Requirements
- R1: A write to the reload register (offset 0x0) stores only bits [8:0] of the data. Bits [31:9] have no effect on the period.
- R2: With reload value R, one period lasts exactly (R+1)*CLK_PER_MS clock cycles, for every R from 0 up to 511.
- R3: A write to the reload register drives `tick_irq` low on the next clock edge, even when `tick_irq` was high. It also restarts the period: the next rise comes exactly (R+1)*CLK_PER_MS cycles after the edge that takes the write.
- R4: At each expiry `tick_irq` rises on that clock edge. The next period then begins at once, with no software action, and `tick_irq` never rises without an expiry.
- R5: A read of the acknowledge register (offset 0x8) drives `tick_irq` low on the next clock edge, provided no expiry falls on that edge.
- R6: After reset `tick_irq` is low and the reload value is 0. The first rise comes CLK_PER_MS cycles after reset is released.
- R7: These accesses change neither `tick_irq` nor the timing of later rises: a read at the reload offset, a write at the acknowledge offset, and any access at another offset.
- R8: When an expiry and an acknowledge read fall on the same clock edge, the expiry takes priority and `tick_irq` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| tick_irq | output | 1 | Periodic interrupt, level high |

## Verification
A rise of `tick_irq` is due exactly (R+1)*CLK_PER_MS cycles after the edge that takes a reload write, or after reset release. The bench counts edges from that reference point and queues each expected rise cycle. The monitor pops one entry on every observed rise and compares the edge count against it, so a rise that comes one cycle early or late is reported. Clears from an acknowledge read or a reload write are due one edge after the strobe, and the bench samples the line at the following falling edge. The collision case for R8 is set up by placing the acknowledge strobe on the same edge as a queued expiry.

// File: rtl/tick_pkg.sv
package tick_pkg;
    localparam int RELOAD_W = 9;
    localparam int DATA_W   = 32;

    typedef struct packed {
        logic [RELOAD_W-1:0] reload;
        logic                irq;
    } ctl_state_t;
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
    parameter int CLK_PER_MS = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic ms_tick
);
    localparam int CNT_W = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CLK_PER_MS - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        ms_tick = (cnt_q == LAST);
        cnt_d   = cnt_q;
        if (restart || ms_tick) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/tick_period.sv
module tick_period #(
    parameter int RELOAD_W = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                restart,
    input  logic                ms_tick,
    input  logic [RELOAD_W-1:0] reload,
    output logic                expire,
    output logic [RELOAD_W-1:0] ms_cnt
);
    logic [RELOAD_W-1:0] ms_d, ms_q;

    always_comb begin
        expire = ms_tick && (ms_q == reload);
        ms_d   = ms_q;
        if (restart || expire) begin
            ms_d = '0;
        end else if (ms_tick) begin
            ms_d = ms_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ms_q <= '0;
        end else begin
            ms_q <= ms_d;
        end
    end

    assign ms_cnt = ms_q;
endmodule

// File: rtl/tick_timer_top.sv
module tick_timer_top
    import tick_pkg::*;
#(
    parameter int                CLK_PER_MS = 50000,
    parameter int                ADDR_W     = 4,
    parameter logic [ADDR_W-1:0] RELOAD_OFS = 4'h0,
    parameter logic [ADDR_W-1:0] ACK_OFS    = 4'h8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              tick_irq
);
    ctl_state_t          st_d, st_q;
    logic                wr_reload;
    logic                rd_ack;
    logic                ms_tick;
    logic                expire;
    logic [RELOAD_W-1:0] ms_cnt;
    logic [RELOAD_W-1:0] reload_cur;
    logic                unused_wdata_hi;

    assign wr_reload       = bus_wr && (bus_addr == RELOAD_OFS);
    assign rd_ack          = bus_rd && (bus_addr == ACK_OFS);
    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:RELOAD_W];
    assign reload_cur      = st_q.reload;

    tick_prescaler #(.CLK_PER_MS(CLK_PER_MS)) i_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (wr_reload),
        .ms_tick (ms_tick)
    );

    tick_period #(.RELOAD_W(RELOAD_W)) i_per (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (wr_reload),
        .ms_tick (ms_tick),
        .reload  (st_q.reload),
        .expire  (expire),
        .ms_cnt  (ms_cnt)
    );

    // Priority: reload write, then expiry, then acknowledge.
    always_comb begin
        st_d = st_q;
        if (wr_reload) begin
            st_d.reload = bus_wdata[RELOAD_W-1:0];
            st_d.irq    = 1'b0;
        end else if (expire) begin
            st_d.irq = 1'b1;
        end else if (rd_ack) begin
            st_d.irq = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_irq = st_q.irq;
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
    parameter int RELOAD_W = 9
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_reload,
    input logic                rd_ack,
    input logic                expire,
    input logic [RELOAD_W-1:0] ms_cnt,
    input logic [RELOAD_W-1:0] reload,
    input logic                irq
);
    // R3
    reload_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_reload |=> !irq);

    // R5
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && !expire && !wr_reload) |=> !irq);

    // R8
    expire_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !wr_reload) |=> irq);

    // R4
    rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(expire));

    // R2
    ms_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ms_cnt <= reload);
endmodule

bind tick_timer_top tick_timer_chk #(.RELOAD_W(tick_pkg::RELOAD_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_reload (wr_reload),
    .rd_ack    (rd_ack),
    .expire    (expire),
    .ms_cnt    (ms_cnt),
    .reload    (reload_cur),
    .irq       (tick_irq)
);

// File: tb/test_tick_timer_top.sv
module test_tick_timer_top;
    localparam int N = 5;
    localparam logic [3:0] RLD = 4'h0;
    localparam logic [3:0] ACK = 4'h8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        tick_irq;

    int cyc = 0;
    int q[$];
    int n_cmp = 0;
    int n_bad = 0;
    int last_w = 0;
    logic irq_prev = 1'b0;

    always #10 clk = ~clk;

    tick_timer_top #(.CLK_PER_MS(N), .ADDR_W(4), .RELOAD_OFS(RLD), .ACK_OFS(ACK)) i_tick_timer_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .tick_irq  (tick_irq)
    );

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // Monitor: every rise of the interrupt is matched against the queue.
    always @(posedge clk) begin
        #5;
        if (rst_n) begin
            if (tick_irq && !irq_prev) begin
                if (q.size() == 0) begin
                    check("R4 unexpected rise", cyc, -1);
                end else begin
                    check("R2/R4 rise cycle", cyc, q.pop_front());
                end
            end
            irq_prev = tick_irq;
        end
    end

    task automatic arm(input int r, input int w, input int k);
        q.delete();
        for (int i = 1; i <= k; i++) q.push_back(w + i * (r + 1) * N);
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        last_w = cyc;
    endtask

    task automatic bus_read(input logic [3:0] a);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_irq();
        @(negedge clk);
        while (!tick_irq) @(negedge clk);
    endtask

    task automatic wait_rise_ack();
        wait_irq();
        bus_read(ACK);
        check("R5 ack clears", int'(tick_irq), 0);
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL R4 watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int x;
        repeat (3) @(negedge clk);
        check("R6 irq low in reset", int'(tick_irq), 0);
        rst_n = 1'b1;
        check("R6 irq low after reset", int'(tick_irq), 0);
        arm(0, 0, 3);
        repeat (3) wait_rise_ack();

        // R1: upper bits dropped, reload 5
        bus_write(RLD, 32'hFFFF_FE05);
        check("R3 write clears", int'(tick_irq), 0);
        arm(5, last_w, 1);
        wait_irq();
        // R7: non-acknowledging accesses while the line is high
        bus_read(RLD);
        check("R7 read reload offset", int'(tick_irq), 1);
        bus_write(ACK, 32'h0000_0001);
        check("R7 write ack offset", int'(tick_irq), 1);
        bus_read(4'hC);
        check("R7 other offset", int'(tick_irq), 1);
        // R3: write while high clears and restarts
        bus_write(RLD, 32'h0000_0002);
        check("R3 write clears high irq", int'(tick_irq), 0);
        arm(2, last_w, 2);
        repeat (2) wait_rise_ack();

        // R8: acknowledge on the same edge as an expiry
        bus_write(RLD, 32'h0000_0001);
        arm(1, last_w, 2);
        x = last_w + 2 * N;
        while (cyc != x - 2) @(negedge clk);
        bus_read(ACK);
        check("R8 expiry wins over ack", int'(tick_irq), 1);
        bus_read(ACK);
        check("R5 ack after collision", int'(tick_irq), 0);
        wait_rise_ack();

        // R2 boundary: largest reload, with an ignored write in the middle
        bus_write(RLD, 32'h0000_01FF);
        arm(511, last_w, 1);
        bus_write(4'hC, 32'hFFFF_FFFF);
        check("R7 other offset write", int'(tick_irq), 0);
        wait_rise_ack();

        check("R4 all rises seen", q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule